// File: doc/BRIEF.md
# Three-Finger Rake Combiner with Differential QPSK Detection

This block sits behind three chip-spaced correlator fingers of a direct-sequence receiver. On every symbol strobe each finger delivers a complex despread value, and a pilot-derived complex channel estimate comes with it. The block multiplies each finger value by the conjugate of that finger's estimate. It adds the weighted fingers together, which is maximal-ratio combining. The combined symbol is then compared with the previous combined symbol to recover two bits per symbol.

Detection is differential. The block forms the product of the current combined symbol and the conjugate of the previous one, turns the result by 45 degrees, and slices it on the signs of its two components. A common phase that drifts slowly, such as a residual carrier offset, cancels in this product, so no carrier loop is needed. A mask switches single fingers off. A strobe with every finger masked off is dropped completely.

Top module: `rake_dqpsk_comb`

## Requirements
- R1: While reset is asserted and after it is released, before any symbol is accepted, `out_vld` is 0 and `out_bits` is 2'b00.
- R2: A strobe is accepted when `sym_stb` is 1 and `fing_en` is not all zero. For an accepted strobe that is not the first since reset, `out_vld` is 1 for exactly the clock cycle that follows the cycle in which the strobe was sampled, provided no further strobe follows.
- R3: Finger i contributes y_i·conj(h_i), that is real part yr·hr+yi·hi and imaginary part yi·hr−yr·hi. The combined symbol is the sum of these contributions over the enabled fingers. Finger i uses bits [i*8 +: 8] of each flat input, and every value is signed two's complement.
- R4: When `fing_en[i]` is 0, finger i contributes zero, whatever its data and estimate inputs hold.
- R5: A strobe with `fing_en` equal to 3'b000 produces no `out_vld` and leaves the stored previous symbol unchanged. The next accepted symbol is therefore compared with the last accepted one.
- R6: The first accepted symbol after reset only loads the previous-symbol store and produces no output.
- R7: The phase change from the previous accepted symbol to the current one maps to `out_bits` as follows: 0° gives 2'b00, +90° gives 2'b01, 180° gives 2'b11, and −90° gives 2'b10.
- R8: Let d be current·conj(previous), and let d·(1−j) have real part P and imaginary part Q. Then `out_bits[1]` = (P<0) and `out_bits[0]` = (Q≥0).
- R9: A common phase rotation of the received signal that changes by well under 45° from one symbol to the next does not change any decision.
- R10: `out_bits` is 2'b00 in every cycle in which `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| sym_stb | input | 1 | Strobe: the finger and estimate inputs hold one symbol |
| fing_en | input | 3 | Finger enable mask, bit i for finger i |
| fing_re | input | 24 | Real parts of the despread finger values, 8 bits per finger |
| fing_im | input | 24 | Imaginary parts of the despread finger values |
| est_re | input | 24 | Real parts of the channel estimates, 8 bits per finger |
| est_im | input | 24 | Imaginary parts of the channel estimates |
| out_vld | output | 1 | Pulse: `out_bits` holds a decision |
| out_bits | output | 2 | Gray-coded dibit for the detected phase change |

## Verification
A wrong previous-symbol store does not show at the time it goes wrong. It shows one accepted symbol later, when `out_bits` fails to match the phase step that was driven. The bench therefore checks every symbol of a sequence against its intended step, and it follows an all-masked strobe with a real symbol. A combining error in the conjugate or the mask turns the combined phase, and the corrupted dibit appears two cycles after the strobe. A broken first-symbol flag or a broken latency shows up as an `out_vld` pulse that is missing, appears early or appears extra, and the bench samples that pulse in the cycles just before and just after its expected position.

// File: rtl/rake_pkg.sv
package rake_pkg;
  localparam int DIBIT_W = 2;
  typedef logic [DIBIT_W-1:0] dibit_t;

  // Quadrant of the 45-degree-turned differential product -> Gray dibit.
  function automatic dibit_t quad_to_dibit(input logic re_neg, input logic im_neg);
    dibit_t d;
    d[1] = re_neg;
    d[0] = ~im_neg;
    return d;
  endfunction
endpackage

// File: rtl/rake_rst_sync.sv
module rake_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/rake_finger_mult.sv
module rake_finger_mult #(
  parameter int DW = 8,
  parameter int EW = 8,
  localparam int PW = DW + EW + 1
) (
  input  logic                 en,
  input  logic signed [DW-1:0] y_re,
  input  logic signed [DW-1:0] y_im,
  input  logic signed [EW-1:0] h_re,
  input  logic signed [EW-1:0] h_im,
  output logic signed [PW-1:0] w_re,
  output logic signed [PW-1:0] w_im
);
  logic signed [PW-1:0] yr_x, yi_x, hr_x, hi_x;

  always_comb begin
    yr_x = PW'(y_re);
    yi_x = PW'(y_im);
    hr_x = PW'(h_re);
    hi_x = PW'(h_im);
    if (en) begin
      // y * conj(h)
      w_re = yr_x * hr_x + yi_x * hi_x;
      w_im = yi_x * hr_x - yr_x * hi_x;
    end else begin
      w_re = '0;
      w_im = '0;
    end
  end
endmodule

// File: rtl/rake_combiner.sv
module rake_combiner #(
  parameter int NF = 3,
  parameter int DW = 8,
  parameter int EW = 8,
  localparam int PW = DW + EW + 1,
  localparam int CW = PW + $clog2(NF + 1)
) (
  input  logic [NF-1:0]        en,
  input  logic [NF*DW-1:0]     y_re,
  input  logic [NF*DW-1:0]     y_im,
  input  logic [NF*EW-1:0]     h_re,
  input  logic [NF*EW-1:0]     h_im,
  output logic signed [CW-1:0] sum_re,
  output logic signed [CW-1:0] sum_im
);
  logic signed [PW-1:0] w_re [NF];
  logic signed [PW-1:0] w_im [NF];

  for (genvar g = 0; g < NF; g++) begin : g_finger
    rake_finger_mult #(.DW(DW), .EW(EW)) mult_i (
      .en   (en[g]),
      .y_re (y_re[g*DW +: DW]),
      .y_im (y_im[g*DW +: DW]),
      .h_re (h_re[g*EW +: EW]),
      .h_im (h_im[g*EW +: EW]),
      .w_re (w_re[g]),
      .w_im (w_im[g])
    );
  end

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int i = 0; i < NF; i++) begin
      sum_re = sum_re + CW'(w_re[i]);
      sum_im = sum_im + CW'(w_im[i]);
    end
  end
endmodule

// File: rtl/dqpsk_diff_slicer.sv
module dqpsk_diff_slicer
  import rake_pkg::*;
#(
  parameter int CW = 19,
  localparam int RW = 2 * CW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [CW-1:0] in_re,
  input  logic signed [CW-1:0] in_im,
  output logic                 out_vld,
  output dibit_t               out_bits
);
  logic signed [CW-1:0] prev_re_q, prev_im_q, prev_re_d, prev_im_d;
  logic                 have_q, have_d;
  logic                 vld_q, vld_d;
  dibit_t               bits_q, bits_d;
  logic signed [RW-1:0] cr, ci, pr, pi, dr, di, rot_re, rot_im;

  always_comb begin
    cr = RW'(in_re);
    ci = RW'(in_im);
    pr = RW'(prev_re_q);
    pi = RW'(prev_im_q);
    // current * conj(previous)
    dr = cr * pr + ci * pi;
    di = ci * pr - cr * pi;
    // turn by -45 degrees (scaled): (dr + j di)(1 - j)
    rot_re = dr + di;
    rot_im = di - dr;

    vld_d     = in_vld & have_q;
    bits_d    = vld_d ? quad_to_dibit(rot_re[RW-1], rot_im[RW-1]) : '0;
    have_d    = have_q | in_vld;
    prev_re_d = in_vld ? in_re : prev_re_q;
    prev_im_d = in_vld ? in_im : prev_im_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_re_q <= '0;
      prev_im_q <= '0;
      have_q    <= 1'b0;
      vld_q     <= 1'b0;
      bits_q    <= '0;
    end else begin
      prev_re_q <= prev_re_d;
      prev_im_q <= prev_im_d;
      have_q    <= have_d;
      vld_q     <= vld_d;
      bits_q    <= bits_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_bits = bits_q;
endmodule

// File: rtl/rake_dqpsk_comb.sv
module rake_dqpsk_comb #(
  parameter int NF = 3,
  parameter int DW = 8,
  parameter int EW = 8,
  localparam int PW = DW + EW + 1,
  localparam int CW = PW + $clog2(NF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_stb,
  input  logic [NF-1:0]    fing_en,
  input  logic [NF*DW-1:0] fing_re,
  input  logic [NF*DW-1:0] fing_im,
  input  logic [NF*EW-1:0] est_re,
  input  logic [NF*EW-1:0] est_im,
  output logic             out_vld,
  output logic [1:0]       out_bits
);
  logic                 rst_core_n;
  logic signed [CW-1:0] sum_re, sum_im;
  logic signed [CW-1:0] comb_re_q, comb_im_q, comb_re_d, comb_im_d;
  logic                 comb_vld_q, comb_vld_d;
  logic                 accept;

  rake_rst_sync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  rake_combiner #(.NF(NF), .DW(DW), .EW(EW)) comb_i (
    .en     (fing_en),
    .y_re   (fing_re),
    .y_im   (fing_im),
    .h_re   (est_re),
    .h_im   (est_im),
    .sum_re (sum_re),
    .sum_im (sum_im)
  );

  always_comb begin
    accept     = sym_stb & (|fing_en);
    comb_vld_d = accept;
    comb_re_d  = accept ? sum_re : comb_re_q;
    comb_im_d  = accept ? sum_im : comb_im_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      comb_vld_q <= 1'b0;
      comb_re_q  <= '0;
      comb_im_q  <= '0;
    end else begin
      comb_vld_q <= comb_vld_d;
      comb_re_q  <= comb_re_d;
      comb_im_q  <= comb_im_d;
    end
  end

  dqpsk_diff_slicer #(.CW(CW)) slice_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .in_vld   (comb_vld_q),
    .in_re    (comb_re_q),
    .in_im    (comb_im_q),
    .out_vld  (out_vld),
    .out_bits (out_bits)
  );
endmodule

// File: rtl/rake_dqpsk_comb_chk.sv
module rake_dqpsk_comb_chk #(
  parameter int NF = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sym_stb,
  input logic [NF-1:0] fing_en,
  input logic          out_vld,
  input logic [1:0]    out_bits
);
  logic [1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 2'd0;
    else if (sym_stb && (|fing_en) && acc_q != 2'd3) acc_q <= acc_q + 2'd1;
  end

  a_r1_outputs_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({out_vld, out_bits}));

  // R2 and R5: a pulse needs an accepted strobe two edges earlier
  a_r2_pulse_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ($past(sym_stb, 2) && ($past(fing_en, 2) != '0)));

  a_r6_first_symbol_silent: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (acc_q >= 2'd2));

  a_r10_bits_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_bits == 2'b00));
endmodule

bind rake_dqpsk_comb rake_dqpsk_comb_chk #(.NF(NF)) chk_i (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .sym_stb  (sym_stb),
  .fing_en  (fing_en),
  .out_vld  (out_vld),
  .out_bits (out_bits)
);

// File: tb/rake_dqpsk_comb_tb_top.sv
module rake_dqpsk_comb_tb_top;
  localparam int NF = 3;
  localparam int DW = 8;
  localparam int A  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sym_stb = 1'b0;
  logic [NF-1:0]    fing_en = '0;
  logic [NF*DW-1:0] fing_re = '0, fing_im = '0, est_re = '0, est_im = '0;
  logic             out_vld;
  logic [1:0]       out_bits;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit have_prev = 1'b0;
  int last_q = 0;

  int h_re [NF] = '{20, -7, 3};
  int h_im [NF] = '{5, 12, -15};

  always #5 clk = ~clk;

  rake_dqpsk_comb dut_i (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .fing_en(fing_en),
    .fing_re(fing_re), .fing_im(fing_im), .est_re(est_re), .est_im(est_im),
    .out_vld(out_vld), .out_bits(out_bits)
  );

  function automatic logic [1:0] gray_of(input int step);
    case (((step % 4) + 4) % 4)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sym_stb = 1'b0;
    repeat (2) @(negedge clk);
    check(out_vld == 1'b0 && out_bits == 2'b00, "R1 in reset", {out_vld, out_bits}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_vld == 1'b0 && out_bits == 2'b00, "R1 after release", {out_vld, out_bits}, 0);
    have_prev = 1'b0;
  endtask

  // Drives one strobe with finger values yr/yi, checks the pulse around its slot.
  task automatic send(input int yr[NF], input int yi[NF], input int hr[NF], input int hi[NF],
                      input logic [NF-1:0] m, input int q, input string req);
    bit accept;
    bit exp_v;
    logic [1:0] exp_b;
    @(negedge clk);
    check(out_vld == 1'b0, "R2 pulse is one cycle", out_vld, 0);
    for (int i = 0; i < NF; i++) begin
      fing_re[i*DW +: DW] = DW'(yr[i]);
      fing_im[i*DW +: DW] = DW'(yi[i]);
      est_re[i*DW +: DW]  = DW'(hr[i]);
      est_im[i*DW +: DW]  = DW'(hi[i]);
    end
    fing_en = m;
    sym_stb = 1'b1;
    accept = (m != '0);
    exp_v = accept && have_prev;
    exp_b = exp_v ? gray_of(q - last_q) : 2'b00;
    @(negedge clk);
    sym_stb = 1'b0;
    check(out_vld == 1'b0, "R2 no early pulse", out_vld, 0);
    @(negedge clk);
    check(out_vld == exp_v, {req, " valid"}, out_vld, exp_v);
    check(out_bits == exp_b, {req, " bits"}, out_bits, exp_b);
    if (accept) begin
      have_prev = 1'b1;
      last_q = q;
    end
  endtask

  // Enabled fingers carry h_i * A * j^q; disabled fingers carry large garbage.
  task automatic send_sym(input logic [NF-1:0] m, input int q, input string req);
    int yr [NF];
    int yi [NF];
    int hr [NF];
    int hi [NF];
    int sr, si;
    case (((q % 4) + 4) % 4)
      0: begin sr = A;  si = 0;  end
      1: begin sr = 0;  si = A;  end
      2: begin sr = -A; si = 0;  end
      default: begin sr = 0; si = -A; end
    endcase
    for (int i = 0; i < NF; i++) begin
      if (m[i]) begin
        hr[i] = h_re[i];
        hi[i] = h_im[i];
        yr[i] = h_re[i] * sr - h_im[i] * si;
        yi[i] = h_re[i] * si + h_im[i] * sr;
      end else begin
        hr[i] = 100;
        hi[i] = -100;
        yr[i] = -100;
        yi[i] = 90;
      end
    end
    send(yr, yi, hr, hi, m, q, req);
  endtask

  initial begin
    int q;
    do_reset();

    // R6: first accepted symbol silent
    q = 0;
    send_sym(3'b111, q, "R6 first symbol");

    // R3 R4 R7 R8: sweep all non-zero masks and all phase steps
    for (int m = 1; m < 8; m++) begin
      for (int k = 0; k < 12; k++) begin
        q = q + ((k + m) % 4);
        send_sym(NF'(m), q, (m == 7) ? "R3 R7 R8 all fingers" : "R4 R7 masked fingers");
      end
    end

    // R5: all-masked strobe ignored, next symbol compares with last accepted
    for (int k = 0; k < 4; k++) begin
      send_sym(3'b000, q + 1 + k, "R5 masked strobe");
      q = q + k + 1;
      send_sym(3'b101, q, "R5 after masked strobe");
    end

    // R6 again after a mid-run reset
    do_reset();
    send_sym(3'b010, 2, "R6 first after re-reset");
    send_sym(3'b010, 3, "R7 after re-reset");

    // R9: slow common drift, single finger with unit estimate
    do_reset();
    begin
      int yr [NF];
      int yi [NF];
      int hr [NF];
      int hi [NF];
      int qs, br, bi, tr;
      qs = 0;
      for (int k = 0; k < 8; k++) begin
        qs = qs + ((3 * k + 1) % 4);
        br = 40;
        bi = 4 * k;
        for (int r = 0; r < (qs % 4); r++) begin
          tr = br;
          br = -bi;
          bi = tr;
        end
        for (int i = 0; i < NF; i++) begin
          yr[i] = 0; yi[i] = 0; hr[i] = 0; hi[i] = 0;
        end
        yr[0] = br; yi[0] = bi; hr[0] = 1; hi[0] = 0;
        send(yr, yi, hr, hi, 3'b001, qs, "R9 drifting phase");
      end
    end

    @(negedge clk);
    check(out_vld == 1'b0 && out_bits == 2'b00, "R10 idle outputs", {out_vld, out_bits}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule